// File: doc/BRIEF.md
# Four-Phase Handshake Clock-Domain Transfer Channel

This block carries one data word at a time from a sending clock domain to a receiving clock domain when the two clocks have no fixed relation. On the sending side a word is offered with a valid/ready pair. The sending controller registers the word, holds it on an internal bus and raises a request line. The receiving controller sees the request after a synchronizer chain. It captures the bus, presents the word for one cycle, and then raises an acknowledge line. That line returns through a second synchronizer.

The exchange is fully interlocked and returns to zero. The request drops only once the acknowledge has been seen high. The acknowledge drops only once the request has been seen low. The sender becomes ready again only after both lines are back at zero. Each of the two handshake lines is sampled raw by exactly one flip-flop, the first stage of its chain. The data bus is never synchronized: it is stable whenever the receiver samples it.

Top module: `hs4_xfer_channel`

## Requirements
- R1: Every transfer moves through four events in a fixed order: request rises, acknowledge rises, request falls, acknowledge falls. All words leave the receiver in the same order they were accepted, each exactly once.
- R2: The receiver raises the acknowledge in the same cycle that it captures and presents the word. The sender stays busy (in_ready_o low) until that acknowledge has reached it and the word has been delivered.
- R3: A new word is accepted only while both the request and the synchronized acknowledge are low.
- R4: Each handshake line crossing into a domain passes through SYNC_STAGES (at least 2) cascaded flip-flops before any logic uses it. A transfer therefore keeps in_ready_o low for at least 2*SYNC_STAGES sender cycles.
- R5: The word driven to the receiver stays unchanged from the rise of the request until the acknowledge is observed. The delivered out_data_o equals the accepted in_data_i bit for bit.
- R6: A word is accepted on a sender rising edge only when in_valid_i and in_ready_o are both high. in_valid_i and in_data_i have no effect while in_ready_o is low.
- R7: Each delivered word appears as out_valid_o high for exactly one receiver cycle, with the word on out_data_o in that cycle.
- R8: After reset both handshake lines are low, in_ready_o is high and out_valid_o is low. Each reset is asserted asynchronously and released synchronously to its own clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk_i | input | 1 | Sender domain clock |
| src_rst_ni | input | 1 | Sender domain reset, active low |
| in_valid_i | input | 1 | Sender offers a word |
| in_ready_o | output | 1 | Sender idle, able to take a word |
| in_data_i | input | DATA_W | Word offered by the sender |
| dst_clk_i | input | 1 | Receiver domain clock |
| dst_rst_ni | input | 1 | Receiver domain reset, active low |
| out_valid_o | output | 1 | One-cycle strobe for a delivered word |
| out_data_o | output | DATA_W | Delivered word, valid with out_valid_o |

## Verification
The bench builds the channel with DATA_W = 16 and SYNC_STAGES = 2. The sender runs at 50 MHz and the receiver at a 13 ns period, so the phase between the two clock edges keeps shifting. This places request and acknowledge edges at every relative offset between the two clocks. With 16 bits, the all-zero, all-one and alternating patterns can be checked alongside random words. The shortest legal busy window of four sender cycles can be compared directly against the measured duration of in_ready_o low. Transfers with gaps of zero to three cycles between them, together with junk offered while the sender is busy, exercise the acceptance rule and the return-to-zero interlock.

// File: rtl/hs4_pkg.sv
`timescale 1ns/1ps
package hs4_pkg;

  // Sender side: idle, request held high, request dropped waiting for ack low
  typedef enum logic [1:0] {
    RQ_IDLE  = 2'd0,
    RQ_RAISE = 2'd1,
    RQ_DROP  = 2'd2
  } rq_state_e;

  // Receiver side: waiting for request, acknowledge held high
  typedef enum logic {
    RS_WAIT = 1'b0,
    RS_HOLD = 1'b1
  } rs_state_e;

endpackage

// File: rtl/hs4_sync.sv
`timescale 1ns/1ps
// Cascaded flip-flop synchronizer. Only stage 0 sees the raw input.
module hs4_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hs4_requester.sv
`timescale 1ns/1ps
module hs4_requester
  import hs4_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              ack_async_i,
  output logic              req_o,
  output logic [DATA_W-1:0] data_o
);

  rq_state_e         state_q, state_d;
  logic              req_q, req_d;
  logic [DATA_W-1:0] data_q;
  logic              data_en;
  logic              ack_s;

  hs4_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ack_async_i),
    .q_o    (ack_s)
  );

  always_comb begin
    state_d = state_q;
    data_en = 1'b0;
    unique case (state_q)
      RQ_IDLE: begin
        if (in_valid_i) begin
          data_en = 1'b1;
          state_d = RQ_RAISE;
        end
      end
      RQ_RAISE: if (ack_s)  state_d = RQ_DROP;
      RQ_DROP:  if (!ack_s) state_d = RQ_IDLE;
      default:  state_d = RQ_IDLE;
    endcase
    req_d = (state_d == RQ_RAISE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RQ_IDLE;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (data_en) data_q <= in_data_i;
  end

  assign in_ready_o = (state_q == RQ_IDLE);
  assign req_o      = req_q;
  assign data_o     = data_q;

  // R1: request rises only while the returned acknowledge is low
  assert_req_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> !$past(ack_s));
  // R2: request falls only after the acknowledge has been seen high
  assert_req_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_q) |-> $past(ack_s));
  // R3: idle implies both handshake lines low
  assert_idle_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (!req_q && !ack_s));
  // R5: word held while the request stays high
  assert_data_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && $past(req_q)) |-> $stable(data_q));
  // R6: a request starts only from an accepted offer
  assert_accept_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(in_valid_i && in_ready_o));

endmodule

// File: rtl/hs4_responder.sv
`timescale 1ns/1ps
module hs4_responder
  import hs4_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_async_i,
  input  logic [DATA_W-1:0] data_async_i,
  output logic              ack_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);

  rs_state_e         state_q, state_d;
  logic              ack_q, ack_d;
  logic              stb_q;
  logic              cap_en;
  logic [DATA_W-1:0] word_q;
  logic              req_s;

  hs4_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (req_async_i),
    .q_o    (req_s)
  );

  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    unique case (state_q)
      RS_WAIT: begin
        if (req_s) begin
          cap_en  = 1'b1;
          state_d = RS_HOLD;
        end
      end
      RS_HOLD: if (!req_s) state_d = RS_WAIT;
      default: state_d = RS_WAIT;
    endcase
    ack_d = (state_d == RS_HOLD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RS_WAIT;
      ack_q   <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      stb_q   <= cap_en;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (cap_en) word_q <= data_async_i;
  end

  assign ack_o       = ack_q;
  assign out_valid_o = stb_q;
  assign out_data_o  = word_q;

  // R1: acknowledge rises only on a seen request
  assert_ack_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(req_s));
  // R1: acknowledge falls only once the request is seen low
  assert_ack_fall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_q) |-> !$past(req_s));
  // R2: strobe coincides with a raised acknowledge
  assert_strobe_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ack_q);
  // R7: strobe lasts a single cycle
  assert_strobe_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

endmodule

// File: rtl/hs4_xfer_channel.sv
`timescale 1ns/1ps
module hs4_xfer_channel #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk_i,
  input  logic              src_rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              dst_clk_i,
  input  logic              dst_rst_ni,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);

  localparam int RST_STAGES = 2;

  logic              src_rst_n_s, dst_rst_n_s;
  logic              req_w, ack_w;
  logic [DATA_W-1:0] bus_w;

  // R8: resets asserted asynchronously, released on the local clock
  hs4_sync #(.STAGES(RST_STAGES)) u_src_rst (
    .clk_i  (src_clk_i),
    .rst_ni (src_rst_ni),
    .d_i    (1'b1),
    .q_o    (src_rst_n_s)
  );

  hs4_sync #(.STAGES(RST_STAGES)) u_dst_rst (
    .clk_i  (dst_clk_i),
    .rst_ni (dst_rst_ni),
    .d_i    (1'b1),
    .q_o    (dst_rst_n_s)
  );

  hs4_requester #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_req (
    .clk_i       (src_clk_i),
    .rst_ni      (src_rst_n_s),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_data_i   (in_data_i),
    .ack_async_i (ack_w),
    .req_o       (req_w),
    .data_o      (bus_w)
  );

  hs4_responder #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rsp (
    .clk_i        (dst_clk_i),
    .rst_ni       (dst_rst_n_s),
    .req_async_i  (req_w),
    .data_async_i (bus_w),
    .ack_o        (ack_w),
    .out_valid_o  (out_valid_o),
    .out_data_o   (out_data_o)
  );

endmodule

// File: tb/hs4_xfer_channel_tb_top.sv
`timescale 1ns/1ps
module hs4_xfer_channel_tb_top;

  localparam int DW     = 16;
  localparam int SS     = 2;
  localparam int NWORDS = 300;

  logic          src_clk = 1'b0;
  logic          dst_clk = 1'b0;
  logic          src_rst_n = 1'b0;
  logic          dst_rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic          out_valid;
  logic [DW-1:0] out_data;

  logic [DW-1:0] exp_q [NWORDS];
  int tx_cnt = 0, rx_cnt = 0, n_chk = 0, n_bad = 0;
  logic prev_v = 1'b0;

  always #10  src_clk = ~src_clk;
  always #6.5 dst_clk = ~dst_clk;

  hs4_xfer_channel #(.DATA_W(DW), .SYNC_STAGES(SS)) dut_i (
    .src_clk_i   (src_clk),
    .src_rst_ni  (src_rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_data_i   (in_data),
    .dst_clk_i   (dst_clk),
    .dst_rst_ni  (dst_rst_n),
    .out_valid_o (out_valid),
    .out_data_o  (out_data)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] pick_word(input int idx);
    case (idx)
      0:       return '0;
      1:       return '1;
      2:       return {(DW/2){2'b01}};
      3:       return {(DW/2){2'b10}};
      default: return DW'($urandom);
    endcase
  endfunction

  // receiver monitor: R7 strobe width, R5/R1 content and order, R6 no extra word
  always @(negedge dst_clk) begin
    if (dst_rst_n && out_valid) begin
      check(!prev_v, "R7", "strobe longer than one cycle", 1, 0);
      if (rx_cnt >= tx_cnt)
        check(1'b0, "R6", "word delivered without acceptance", out_data, 0);
      else
        check(out_data === exp_q[rx_cnt], "R5", "delivered word", out_data, exp_q[rx_cnt]);
      rx_cnt++;
    end
    prev_v = out_valid;
  end

  task automatic send(input logic [DW-1:0] w, input bit junk);
    int low_cnt;
    @(negedge src_clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge src_clk);
    check(rx_cnt == tx_cnt, "R3", "accept before previous word done", rx_cnt, tx_cnt);
    exp_q[tx_cnt] = w;
    tx_cnt++;
    @(negedge src_clk);
    in_valid = 1'b0;
    low_cnt  = 0;
    while (!in_ready) begin
      if (junk) begin
        in_valid = 1'b1;           // R6: offers while busy must be ignored
        in_data  = ~w;
      end
      low_cnt++;
      @(negedge src_clk);
    end
    in_valid = 1'b0;
    check(low_cnt + 1 >= 2*SS, "R4", "busy window too short", low_cnt + 1, 2*SS);
    check(rx_cnt == tx_cnt, "R2", "ready returned before delivery", rx_cnt, tx_cnt);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge src_clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d words expected %0d", rx_cnt, NWORDS);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge src_clk);
    src_rst_n = 1'b1;
    @(negedge dst_clk);
    dst_rst_n = 1'b1;
    repeat (4) @(negedge src_clk);
    // R8: state after reset
    check(in_ready === 1'b1, "R8", "in_ready after reset", in_ready, 1);
    check(out_valid === 1'b0, "R8", "out_valid after reset", out_valid, 0);
    // R6: offer while held in reset-release period already idle; ignored valid low
    for (int i = 0; i < NWORDS; i++) begin
      int gap;
      bit junk;
      gap  = (i < 8) ? 0 : int'($urandom % 4);
      junk = (i % 5 == 3);
      repeat (gap) @(negedge src_clk);
      send(pick_word(i), junk);
    end
    repeat (40) @(negedge src_clk);
    // R1: every word delivered once and in order
    check(rx_cnt == NWORDS, "R1", "total words delivered", rx_cnt, NWORDS);
    check(out_valid === 1'b0, "R7", "strobe idle at end", out_valid, 0);
    check(in_ready === 1'b1, "R3", "idle at end", in_ready, 1);
    finish_run();
  end

endmodule